// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This bridge gives a host on a 16-bit register bus a way to reach the management registers of several PHYs that sit behind it. Each PHY has a number of pages, and each page has thirty-two registers. The host does not address these registers directly. It first writes a direction code to a control register. It then writes to a composite bus address whose bits name the PHY, the page and the register.

When the direction is write, the data of that composite-address write goes to the PHY register unchanged. When the direction is read, the bridge fetches the PHY value and holds it in a data register, which the host then reads over the bus. The PHY side uses a simple handshake. A one-cycle request carries the target and the write data. The PHY answers with an acknowledge pulse that carries the read data. A busy flag covers the time between the request and the acknowledge. An error flag reports composite addresses that do not name exactly one PHY or that name a page above the limit.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset, busy, err and phy_req are 0, the direction is write, and both the control register (0x8000) and the data register (0x8002) read back 0.
- R2: A bus write to 0x8000 latches bit 0 as the direction (1 = read, 0 = write), and a read of 0x8000 returns that bit in bit 0 with all other bits 0.
- R3: A composite address has bit 15 set. Bits 13:9 form a one-hot PHY select, with bit 9+n selecting PHY n. Bits 8:5 hold the page and bits 4:0 the register. A valid composite write raises phy_req with phy_sel = n (binary), phy_page and phy_reg taken from those fields.
- R4: In write direction, the request has phy_we = 1 and phy_wdata equal to the data of the composite-address write.
- R5: In read direction, the request has phy_we = 0. The phy_rdata value present with the acknowledge is stored in the data register and is returned by a later read of 0x8002.
- R6: phy_req is high for exactly one cycle, in the cycle after the clock edge that accepts the composite write.
- R7: busy rises together with phy_req and stays high until the edge that samples phy_ack, after which it is 0. With an acknowledge N cycles after the request cycle, busy is high for N+1 cycles.
- R8: A write to a composite address while busy produces no request, leaves err unchanged and does not disturb the access in flight.
- R9: A write to an address with bit 15 set, other than 0x8000 or 0x8002, is an error when bits 14:9 do not hold exactly one set bit within 13:9, or when the page is above 7. An error produces no request, sets err, and makes the data register read 0xFFFF. The next valid composite access clears err.
- R10: The data register keeps its value through write-direction accesses and changes only on a read acknowledge or an error.
- R11: host_rdata is registered and is valid in the cycle after host_rd. Reads of any address other than 0x8000 and 0x8002 return 0.
- R12: phy_ack while not busy has no effect on busy, err or the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| busy | output | 1 | PHY access in flight |
| err | output | 1 | Last composite access was malformed |
| phy_req | output | 1 | One-cycle request to the PHY register port |
| phy_sel | output | 3 | Target PHY number |
| phy_page | output | 4 | Target page |
| phy_reg | output | 5 | Target register |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_wdata | output | 16 | Data to write |
| phy_ack | input | 1 | PHY acknowledge |
| phy_rdata | input | 16 | Read data, valid with phy_ack |

## Verification
The bench builds the bridge with its default parameters: five PHYs, a four-bit page field limited to 7, and five-bit register numbers. With these values the highest select bit sits at bit 13, so bit 14 becomes an out-of-range select bit, and pages 8 to 15 can be encoded but are illegal. The bench PHY model uses an acknowledge latency that can be set per test. This covers an acknowledge in the same cycle as the request, short and long waits, and a long wait during which a second composite write arrives while busy.

// File: rtl/pib_pkg.sv
package pib_pkg;
  // fixed host-visible locations inside the indirect window
  localparam logic [15:0] CTRL_ADDR = 16'h8000;
  localparam logic [15:0] DATA_ADDR = 16'h8002;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } pib_dir_e;
endpackage

// File: rtl/pib_decode.sv
module pib_decode #(
  parameter int AW       = 16,
  parameter int NPHY     = 5,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 7,
  parameter int REG_W    = 5,
  parameter int IDX_W    = 3
) (
  input  logic [AW-1:0]     addr,
  output logic              is_ctrl,
  output logic              is_data,
  output logic              is_win,
  output logic              good,
  output logic [IDX_W-1:0]  idx,
  output logic [PAGE_W-1:0] page,
  output logic [REG_W-1:0]  regn
);
  import pib_pkg::*;

  localparam int SEL_LSB = REG_W + PAGE_W;
  localparam int SELF_W  = AW - 1 - SEL_LSB;

  logic [SELF_W-1:0] sel_f;
  logic              extra;

  assign sel_f   = addr[AW-2:SEL_LSB];
  assign page    = addr[REG_W +: PAGE_W];
  assign regn    = addr[REG_W-1:0];
  assign is_ctrl = (addr == AW'(CTRL_ADDR));
  assign is_data = (addr == AW'(DATA_ADDR));
  assign is_win  = addr[AW-1] && !is_ctrl && !is_data;

  // select bits above the last PHY are always illegal
  generate
    if (SELF_W > NPHY) begin : g_extra
      assign extra = |sel_f[SELF_W-1:NPHY];
    end else begin : g_noextra
      assign extra = 1'b0;
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = 0; k < NPHY; k++) begin
      if (sel_f[k]) idx = idx | IDX_W'(k);
    end
  end

  assign good = is_win && $onehot(sel_f[NPHY-1:0]) && !extra &&
                (page <= PAGE_W'(PAGE_MAX));
endmodule

// File: rtl/pib_cmd.sv
module pib_cmd #(
  parameter int DW     = 16,
  parameter int PAGE_W = 4,
  parameter int REG_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              is_ctrl,
  input  logic              is_win,
  input  logic              good,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAGE_W-1:0] page,
  input  logic [REG_W-1:0]  regn,
  input  logic              phy_ack,
  output logic              phy_req,
  output logic [IDX_W-1:0]  phy_sel,
  output logic [PAGE_W-1:0] phy_page,
  output logic [REG_W-1:0]  phy_reg,
  output logic              phy_we,
  output logic [DW-1:0]     phy_wdata,
  output logic              busy,
  output logic              err,
  output logic              dir,
  output logic              bad_stb,
  output logic              rd_done
);
  import pib_pkg::*;

  pib_dir_e dir_q;
  logic     accept;

  assign accept  = host_wr && is_win && !busy;
  assign bad_stb = accept && !good;
  assign rd_done = busy && phy_ack && !phy_we;
  assign dir     = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= DIR_WRITE;
      busy      <= 1'b0;
      err       <= 1'b0;
      phy_req   <= 1'b0;
      phy_sel   <= '0;
      phy_page  <= '0;
      phy_reg   <= '0;
      phy_we    <= 1'b0;
      phy_wdata <= '0;
    end else begin
      phy_req <= 1'b0;
      if (host_wr && is_ctrl) dir_q <= pib_dir_e'(host_wdata[0]);
      if (accept) begin
        if (good) begin
          phy_req   <= 1'b1;
          busy      <= 1'b1;
          err       <= 1'b0;
          phy_sel   <= idx;
          phy_page  <= page;
          phy_reg   <= regn;
          phy_we    <= (dir_q == DIR_WRITE);
          phy_wdata <= host_wdata;
        end else begin
          err <= 1'b1;
        end
      end
      if (busy && phy_ack) busy <= 1'b0;
    end
  end

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    phy_req |=> !phy_req);
  assert_req_busy_R7: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> busy);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !phy_ack) |=> busy);
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && phy_ack) |=> !busy);
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && is_win && busy) |=> (!phy_req && $stable(err)));
  assert_idle_ack_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && phy_ack && !host_wr) |=> (!busy && $stable(err)));
endmodule

// File: rtl/pib_regs.sv
module pib_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rd,
  input  logic          is_ctrl,
  input  logic          is_data,
  input  logic          dir,
  input  logic          bad_stb,
  input  logic          rd_done,
  input  logic [DW-1:0] phy_rdata,
  output logic [DW-1:0] host_rdata
);
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (bad_stb) begin
      data_q <= '1;
    end else if (rd_done) begin
      data_q <= phy_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (is_data)      host_rdata <= data_q;
      else if (is_ctrl) host_rdata <= DW'(dir);
      else              host_rdata <= '0;
    end
  end

  assert_ffff_R9: assert property (@(posedge clk) disable iff (rst)
    bad_stb |=> (data_q == '1));
  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !bad_stb) |=> (data_q == $past(phy_rdata)));
  assert_rd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !is_ctrl && !is_data) |=> (host_rdata == '0));
endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int NPHY     = 5,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 7,
  parameter int REG_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [AW-1:0]            host_addr,
  input  logic [DW-1:0]            host_wdata,
  output logic [DW-1:0]            host_rdata,
  output logic                     busy,
  output logic                     err,
  output logic                     phy_req,
  output logic [$clog2(NPHY)-1:0]  phy_sel,
  output logic [PAGE_W-1:0]        phy_page,
  output logic [REG_W-1:0]         phy_reg,
  output logic                     phy_we,
  output logic [DW-1:0]            phy_wdata,
  input  logic                     phy_ack,
  input  logic [DW-1:0]            phy_rdata
);
  localparam int IDX_W = $clog2(NPHY);

  logic              is_ctrl, is_data, is_win, good;
  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] page;
  logic [REG_W-1:0]  regn;
  logic              dir, bad_stb, rd_done;

  pib_decode #(.AW(AW), .NPHY(NPHY), .PAGE_W(PAGE_W), .PAGE_MAX(PAGE_MAX),
               .REG_W(REG_W), .IDX_W(IDX_W)) u_dec (
    .addr(host_addr), .is_ctrl(is_ctrl), .is_data(is_data), .is_win(is_win),
    .good(good), .idx(idx), .page(page), .regn(regn));

  pib_cmd #(.DW(DW), .PAGE_W(PAGE_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_cmd (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .is_ctrl(is_ctrl), .is_win(is_win), .good(good), .idx(idx), .page(page),
    .regn(regn), .phy_ack(phy_ack), .phy_req(phy_req), .phy_sel(phy_sel),
    .phy_page(phy_page), .phy_reg(phy_reg), .phy_we(phy_we),
    .phy_wdata(phy_wdata), .busy(busy), .err(err), .dir(dir),
    .bad_stb(bad_stb), .rd_done(rd_done));

  pib_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .host_rd(host_rd), .is_ctrl(is_ctrl),
    .is_data(is_data), .dir(dir), .bad_stb(bad_stb), .rd_done(rd_done),
    .phy_rdata(phy_rdata), .host_rdata(host_rdata));

  assert_bad_err_R9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && is_win && !busy && !good) |=> (err && !phy_req));
  assert_good_req_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && is_win && !busy && good) |=> (phy_req && !err));
endmodule

// File: tb/tb_phy_ind_bridge.sv
module tb_phy_ind_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, err, phy_req, phy_we, phy_ack;
  logic [2:0]  phy_sel;
  logic [3:0]  phy_page;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata, phy_rdata;
  logic        model_ack = 1'b0, stray_ack = 1'b0;
  logic [15:0] model_rd = '0;

  assign phy_ack   = model_ack | stray_ack;
  assign phy_rdata = stray_ack ? 16'hDEAD : model_rd;

  phy_ind_bridge dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .err(err), .phy_req(phy_req), .phy_sel(phy_sel),
    .phy_page(phy_page), .phy_reg(phy_reg), .phy_we(phy_we),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata));

  typedef struct packed {
    logic [2:0]  sel;
    logic [3:0]  page;
    logic [4:0]  rg;
    logic        we;
    logic [15:0] wd;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0, lat = 2;
  bit   done = 0;

  function automatic logic [15:0] phy_val(input logic [2:0] s, input logic [3:0] p,
                                          input logic [4:0] r);
    return {s, p[2:0], r, 5'b10101} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] cmp_addr(input int n, input int p, input int r);
    return 16'h8000 | (16'h1 << (9 + n)) | 16'(p << 5) | 16'(r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // driver: posts the expected request then performs the composite write
  task automatic access(input int n, input int p, input int r, input logic we,
                        input logic [15:0] d);
    exp_t e;
    e.sel = 3'(n); e.page = 4'(p); e.rg = 5'(r); e.we = we; e.wd = d;
    exp_q.push_back(e);
    bus_wr(cmp_addr(n, p, r), d);
  endtask

  // monitor: every request must match the head of the queue
  always @(negedge clk) begin
    if (!rst && phy_req) begin
      if (exp_q.size() == 0) begin
        chk("R8 R9 request with nothing expected", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R3 R4 request fields", 32'({phy_sel, phy_page, phy_reg, phy_we, phy_wdata}),
            32'(e));
      end
    end
  end

  // PHY model with a settable acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && phy_req) begin
        logic [2:0] s; logic [3:0] p; logic [4:0] r;
        s = phy_sel; p = phy_page; r = phy_reg;
        repeat (lat) @(negedge clk);
        model_rd  = phy_val(s, p, r);
        model_ack = 1'b1;
        @(negedge clk);
        model_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 phy_req", 32'(phy_req), 0);
    bus_rd(16'h8002, rd); chk("R1 data register", 32'(rd), 0);
    bus_rd(16'h8000, rd); chk("R1 R2 control register", 32'(rd), 0);

    // R2 direction latch
    bus_wr(16'h8000, 16'hFFFF);
    bus_rd(16'h8000, rd); chk("R2 read direction", 32'(rd), 1);
    bus_wr(16'h8000, 16'h0000);
    bus_rd(16'h8000, rd); chk("R2 write direction", 32'(rd), 0);

    // R4 R6 R7 write access, latency 3
    lat = 3;
    access(2, 3, 17, 1'b1, 16'h1234);
    chk("R6 req after accept", 32'(phy_req), 1);
    chk("R7 busy with req", 32'(busy), 1);
    begin
      int n = 0;
      while (busy) begin @(negedge clk); n++; if (n == 1) chk("R6 single pulse", 32'(phy_req), 0); end
      chk("R7 busy cycles", 32'(n + 0), 32'(lat + 1));
    end
    bus_rd(16'h8002, rd); chk("R10 write keeps data", 32'(rd), 0);

    // R5 read access, top corner
    bus_wr(16'h8000, 16'h0001);
    access(4, 7, 31, 1'b0, 16'h0001);
    wait_idle();
    bus_rd(16'h8002, rd); chk("R5 read phy4 p7 r31", 32'(rd), 32'(phy_val(4, 7, 31)));

    // R5 R7 acknowledge in the request cycle
    lat = 0;
    access(0, 0, 0, 1'b0, 16'h0001);
    chk("R7 busy at req, ack same cycle", 32'(busy), 1);
    @(negedge clk);
    chk("R7 busy cleared", 32'(busy), 0);
    bus_rd(16'h8002, rd); chk("R5 read phy0 p0 r0", 32'(rd), 32'(phy_val(0, 0, 0)));

    // R8 write while busy is ignored
    lat = 6;
    access(1, 5, 9, 1'b0, 16'h0001);
    bus_wr(cmp_addr(3, 2, 4), 16'h0001);
    chk("R8 err unchanged", 32'(err), 0);
    bus_wr(16'h8005, 16'h0000);
    chk("R8 bad address while busy", 32'(err), 0);
    wait_idle();
    bus_rd(16'h8002, rd); chk("R8 first access result", 32'(rd), 32'(phy_val(1, 5, 9)));

    // R9 malformed addresses
    lat = 1;
    bus_wr(16'h8000 | 16'h0400 | 16'h1000 | 16'h0005, 16'h0000);
    chk("R9 two selects no req", 32'(phy_req), 0);
    chk("R9 two selects err", 32'(err), 1);
    bus_rd(16'h8002, rd); chk("R9 data 0xFFFF", 32'(rd), 32'hFFFF);
    access(3, 1, 2, 1'b0, 16'h0001);
    wait_idle();
    chk("R9 err cleared", 32'(err), 0);
    bus_rd(16'h8002, rd); chk("R9 R5 data after recovery", 32'(rd), 32'(phy_val(3, 1, 2)));
    bus_wr(16'h8000 | 16'h4000 | 16'h0003, 16'h0000);
    chk("R9 bit14 select", 32'(err), 1);
    access(0, 0, 1, 1'b0, 16'h0001); wait_idle();
    bus_wr(16'h8000 | 16'h0200 | 16'h0120, 16'h0000);
    chk("R9 page 9", 32'(err), 1);
    access(0, 0, 1, 1'b0, 16'h0001); wait_idle();
    bus_wr(16'h8004, 16'h0000);
    chk("R9 zero select", 32'(err), 1);
    bus_rd(16'h8002, rd); chk("R9 data 0xFFFF again", 32'(rd), 32'hFFFF);

    // R10 write access keeps the last read value
    access(2, 2, 2, 1'b0, 16'h0001); wait_idle();
    bus_wr(16'h8000, 16'h0000);
    access(1, 6, 30, 1'b1, 16'hBEEF); wait_idle();
    bus_rd(16'h8002, rd); chk("R10 kept across write", 32'(rd), 32'(phy_val(2, 2, 2)));

    // R12 stray acknowledge while idle
    @(negedge clk); stray_ack = 1'b1;
    @(negedge clk); stray_ack = 1'b0;
    chk("R12 busy idle", 32'(busy), 0);
    chk("R12 err idle", 32'(err), 0);
    bus_rd(16'h8002, rd); chk("R12 data unchanged", 32'(rd), 32'(phy_val(2, 2, 2)));

    // R11 unmapped read
    bus_rd(16'h0123, rd); chk("R11 unmapped", 32'(rd), 0);
    bus_rd(16'h8001, rd); chk("R11 window hole", 32'(rd), 0);

    repeat (4) @(negedge clk);
    chk("R3 queue drained", 32'(exp_q.size()), 0);
    finish_up();
  end
endmodule